// File: doc/BRIEF.md
# Streaming Convolutional Symbol Equalizer

This block equalizes a stream of received two-level amplitude samples, one sample per symbol, with a small fixed-point one-dimensional convolutional network. Samples enter through a valid/ready stream. The block keeps a sliding window of the most recent samples. Each time eight fresh samples have arrived, it runs the window through three cascaded unpadded convolution layers. It then emits eight hard symbol decisions as a single output beat.

Weights and the folded normalization constants are elaboration-time functions. The block holds no programmable state. The pipeline has three register stages: first layer, second layer, then decision. All three advance together, and they all freeze while the output beat is refused.

Top module: `cnn_equalizer`

## Requirements
- R1: The first pass starts on the 32nd sample accepted after reset. Each later pass starts on every 8th sample accepted after that. Every pass yields exactly one output beat, with none lost and none repeated.
- R2: Each layer is an unpadded convolution with 9 taps. Channel counts are 1 to 4, then 4 to 4, then 4 to 1. The weight for layer L (0..2), output channel o, input channel i and tap k is ((37L + 11o + 5i + 3k) mod 7) - 3. Tap k of output position p reads input position p+k, where position 0 is the oldest sample.
- R3: Layers 0 and 1 apply a per-channel affine step to the accumulator: acc·(1 + (L+o) mod 3) + 32·(((13o + 7L) mod 5) - 2). The result is then requantized as floor((v+16)/32), saturated to [-128, 127], and clamped below at 0.
- R4: Layer 2 has no affine step and no clamp at 0. Its accumulator is requantized and saturated in the same way as in R3. A result of 0 or more gives bit 1, and a negative result gives bit 0.
- R5: Output bit j (0..7) is the decision for the layer-2 position j, which depends on window samples j to j+24.
- R6: The last-beat flag is high on every output beat.
- R7: With the output never refused, the output valid rises after the second clock edge following the edge that accepts the sample completing a window.
- R8: While the output is valid and refused, the output data stays unchanged, input ready is low, and no stage advances.
- R9: Reset clears every sample buffer and counter, drives output valid low and input ready high, and restarts the 32-sample fill.
- R10: Input ready is high whenever no output beat is being refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 8 | Received sample, two's complement |
| in_valid_i | input | 1 | Sample valid |
| in_ready_o | output | 1 | Sample accepted when high together with valid |
| out_bits_o | output | 8 | Eight symbol decisions, bit j for symbol j |
| out_valid_o | output | 1 | Decision beat valid |
| out_ready_i | input | 1 | Downstream accepts the beat |
| out_last_o | output | 1 | Marks each beat as the end of its packet |

## Verification
An input becomes a decision three edges after it is accepted: one edge each for the first layer, the second layer and the decision register. The bench drives inputs just after the falling edge and samples outputs one nanosecond later. It stamps each window-completing acceptance with the rising-edge count and expects the matching beat exactly three counts later whenever the output is never refused. Under random refusal, it instead checks that each refused beat reappears unchanged in the next sampled cycle, that beats come out in window order, and that none are missing after a drain.

// File: rtl/cnn_eq_pkg.sv
package cnn_eq_pkg;
  localparam int DW    = 8;
  localparam int KERN  = 9;
  localparam int NSYM  = 8;
  localparam int NHID  = 4;
  localparam int SHIFT = 5;

  typedef logic signed [DW-1:0] smp_t;

  function automatic int wgt(int layer, int oc, int ic, int k);
    return ((layer * 37 + oc * 11 + ic * 5 + k * 3) % 7) - 3;
  endfunction

  function automatic int bn_scale(int layer, int oc);
    return 1 + ((layer + oc) % 3);
  endfunction

  function automatic int bn_bias(int layer, int oc);
    return (((oc * 13 + layer * 7) % 5) - 2) * 32;
  endfunction

  // round half up, then clip to the sample range
  function automatic smp_t requant(int v);
    int r;
    r = (v + (1 << (SHIFT - 1))) >>> SHIFT;
    if (r > 127) r = 127;
    else if (r < -128) r = -128;
    return smp_t'(r);
  endfunction
endpackage

// File: rtl/cnn_eq_window.sv
module cnn_eq_window import cnn_eq_pkg::*; #(
  parameter int LEN  = 32,
  parameter int STEP = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  smp_t smp_i,
  output smp_t win_o [LEN],
  output logic pass_o
);
  localparam int FW = $clog2(LEN + 1);
  localparam int PW = $clog2(STEP);
  localparam logic [FW-1:0] FULL  = FW'(LEN);
  localparam logic [FW-1:0] PRIME = FW'(LEN - 1);
  localparam logic [PW-1:0] LASTP = PW'(STEP - 1);

  smp_t win_q [LEN];
  logic [FW-1:0] fill_q;
  logic [PW-1:0] phase_q;

  // layer 0 sees the window including the sample accepted this cycle
  always_comb begin
    for (int i = 0; i < LEN - 1; i++) win_o[i] = en_i ? win_q[i+1] : win_q[i];
    win_o[LEN-1] = en_i ? smp_i : win_q[LEN-1];
  end

  assign pass_o = en_i && (phase_q == LASTP) && (fill_q >= PRIME);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q   <= '{default: '0};
      fill_q  <= '0;
      phase_q <= '0;
    end else if (en_i) begin
      win_q   <= win_o;
      phase_q <= phase_q + 1'b1;
      if (fill_q != FULL) fill_q <= fill_q + 1'b1;
    end
  end

  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] chk_cnt;
  logic          chk_seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_cnt  <= '0;
      chk_seen <= 1'b0;
    end else if (en_i) begin
      if (pass_o) begin
        chk_cnt  <= '0;
        chk_seen <= 1'b1;
      end else if (chk_cnt != '1) begin
        chk_cnt <= chk_cnt + 1'b1;
      end
    end
  end

  assert_pass_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> (chk_seen ? (chk_cnt == CW'(STEP - 1)) : (chk_cnt == CW'(LEN - 1))));
endmodule

// File: rtl/cnn_eq_conv.sv
module cnn_eq_conv import cnn_eq_pkg::*; #(
  parameter int LAYER  = 0,
  parameter int IN_CH  = 1,
  parameter int OUT_CH = 4,
  parameter int IN_LEN = 32,
  parameter bit NORM   = 1'b1,
  localparam int OUT_LEN = IN_LEN - KERN + 1
) (
  input  smp_t act_i [IN_CH][IN_LEN],
  output smp_t act_o [OUT_CH][OUT_LEN]
);
  always_comb begin
    int   acc;
    smp_t q;
    for (int oc = 0; oc < OUT_CH; oc++) begin
      for (int p = 0; p < OUT_LEN; p++) begin
        acc = 0;
        for (int ic = 0; ic < IN_CH; ic++)
          for (int k = 0; k < KERN; k++)
            acc += int'(act_i[ic][p+k]) * wgt(LAYER, oc, ic, k);
        if (NORM) acc = acc * bn_scale(LAYER, oc) + bn_bias(LAYER, oc);
        q = requant(acc);
        act_o[oc][p] = (NORM && q < 0) ? smp_t'(0) : q;
      end
    end
  end
endmodule

// File: rtl/cnn_equalizer.sv
module cnn_equalizer import cnn_eq_pkg::*; #(
  parameter int SYMS   = NSYM,
  parameter int HIDDEN = NHID
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [DW-1:0]   in_data_i,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  output logic [SYMS-1:0] out_bits_o,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic            out_last_o
);
  localparam int WIN_LEN = SYMS + 3 * (KERN - 1);
  localparam int L1_LEN  = WIN_LEN - KERN + 1;
  localparam int L2_LEN  = L1_LEN - KERN + 1;

  logic stall, accept, pass;
  smp_t win    [WIN_LEN];
  smp_t l0     [1][WIN_LEN];
  smp_t l1_d   [HIDDEN][L1_LEN];
  smp_t l1_q   [HIDDEN][L1_LEN];
  smp_t l2_d   [HIDDEN][L2_LEN];
  smp_t l2_q   [HIDDEN][L2_LEN];
  smp_t l3_d   [1][SYMS];
  logic v1_q, v2_q;

  assign stall      = out_valid_o && !out_ready_i;
  assign in_ready_o = !stall;
  assign accept     = in_valid_i && in_ready_o;
  assign out_last_o = out_valid_o;

  cnn_eq_window #(.LEN(WIN_LEN), .STEP(SYMS)) u_window (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (accept),
    .smp_i (smp_t'(in_data_i)),
    .win_o (win),
    .pass_o(pass)
  );

  always_comb for (int i = 0; i < WIN_LEN; i++) l0[0][i] = win[i];

  cnn_eq_conv #(.LAYER(0), .IN_CH(1), .OUT_CH(HIDDEN), .IN_LEN(WIN_LEN), .NORM(1'b1))
    u_conv0 (.act_i(l0), .act_o(l1_d));
  cnn_eq_conv #(.LAYER(1), .IN_CH(HIDDEN), .OUT_CH(HIDDEN), .IN_LEN(L1_LEN), .NORM(1'b1))
    u_conv1 (.act_i(l1_q), .act_o(l2_d));
  cnn_eq_conv #(.LAYER(2), .IN_CH(HIDDEN), .OUT_CH(1), .IN_LEN(L2_LEN), .NORM(1'b0))
    u_conv2 (.act_i(l2_q), .act_o(l3_d));

  // all stages share one enable so a refused beat freezes the whole pipe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l1_q        <= '{default: '0};
      l2_q        <= '{default: '0};
      v1_q        <= 1'b0;
      v2_q        <= 1'b0;
      out_valid_o <= 1'b0;
      out_bits_o  <= '0;
    end else if (!stall) begin
      v1_q        <= pass;
      v2_q        <= v1_q;
      out_valid_o <= v2_q;
      if (pass) l1_q <= l1_d;
      if (v1_q) l2_q <= l2_d;
      if (v2_q)
        for (int j = 0; j < SYMS; j++) out_bits_o[j] <= (l3_d[0][j] >= 0);
    end
  end

  assert_hold_beat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall |=> out_valid_o && $stable(out_bits_o));

  assert_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pass, 3) && !$past(stall, 2) && !$past(stall, 1) |-> out_valid_o);

  assert_beat_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(v2_q));

  assert_frozen_stage_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall |=> $stable(v2_q) && $stable(v1_q));
endmodule

// File: tb/cnn_equalizer_bench.sv
`timescale 1ns/1ps
module cnn_equalizer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid, out_last;
  logic [7:0] out_bits;

  int checks = 0, errors = 0, cyc = 0;
  int mw [32];
  int mcount = 0;
  bit lat_on = 0, held = 0;
  logic [7:0] held_bits;
  logic [7:0] exp_q [$];
  int due_q [$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  cnn_equalizer u_cnn_equalizer (
    .clk_i(clk), .rst_ni(rst_n),
    .in_data_i(in_data), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .out_bits_o(out_bits), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_last_o(out_last)
  );

  function automatic int tw(int l, int o, int i, int k);
    return ((37 * l + 11 * o + 5 * i + 3 * k) % 7) - 3;
  endfunction
  function automatic int aff(int acc, int l, int o);
    return acc * (1 + (l + o) % 3) + 32 * (((13 * o + 7 * l) % 5) - 2);
  endfunction
  function automatic int rq(int v);
    int r = (v + 16) >>> 5;
    return (r > 127) ? 127 : (r < -128) ? -128 : r;
  endfunction
  function automatic int relu(int v);
    return (v < 0) ? 0 : v;
  endfunction

  // R2 R3 R4 R5: independent model of all three layers and the bit order
  function automatic logic [7:0] ref_bits(input int w [32]);
    int a1 [4][24];
    int a2 [4][16];
    int acc;
    logic [7:0] b;
    for (int o = 0; o < 4; o++)
      for (int p = 0; p < 24; p++) begin
        acc = 0;
        for (int k = 0; k < 9; k++) acc += w[p+k] * tw(0, o, 0, k);
        a1[o][p] = relu(rq(aff(acc, 0, o)));
      end
    for (int o = 0; o < 4; o++)
      for (int p = 0; p < 16; p++) begin
        acc = 0;
        for (int i = 0; i < 4; i++)
          for (int k = 0; k < 9; k++) acc += a1[i][p+k] * tw(1, o, i, k);
        a2[o][p] = relu(rq(aff(acc, 1, o)));
      end
    for (int p = 0; p < 8; p++) begin
      acc = 0;
      for (int i = 0; i < 4; i++)
        for (int k = 0; k < 9; k++) acc += a2[i][p+k] * tw(2, 0, i, k);
      b[p] = (rq(acc) >= 0);
    end
    return b;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input int d, input bit rdy);
    logic [7:0] e;
    int dv;
    @(negedge clk);
    in_valid = v; in_data = 8'(d); out_ready = rdy;
    #1;
    if (held) chk(out_valid && out_bits == held_bits, "R8 held beat", out_bits, held_bits);
    if (!out_valid) chk(in_ready, "R10 ready", in_ready, 1);
    if (out_valid && !rdy) begin
      chk(!in_ready, "R8 intake blocked", in_ready, 0);
      held = 1; held_bits = out_bits;
    end else held = 0;
    if (out_valid && rdy) begin
      chk(out_last, "R6 last flag", out_last, 1);
      if (exp_q.size() == 0) chk(0, "R1 unexpected beat", out_bits, 0);
      else begin
        e = exp_q.pop_front();
        chk(out_bits == e, "R4 decisions", out_bits, e);
        if (lat_on) begin
          dv = due_q.pop_front();
          chk(cyc == dv, "R7 latency", cyc, dv);
        end
      end
    end
    if (v && in_ready) begin
      for (int i = 0; i < 31; i++) mw[i] = mw[i+1];
      mw[31] = d;
      mcount++;
      if (mcount >= 32 && (mcount - 32) % 8 == 0) begin
        exp_q.push_back(ref_bits(mw));
        if (lat_on) due_q.push_back(cyc + 3);
      end
    end
  endtask

  task automatic drain();
    repeat (8) step(0, 0, 1);
    chk(exp_q.size() == 0, "R1 beat count", exp_q.size(), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; in_valid = 0; out_ready = 1;
    repeat (2) @(negedge clk);
    chk(!out_valid && in_ready && !out_last, "R9 reset state", out_valid, 0);
    rst_n = 1;
    for (int i = 0; i < 32; i++) mw[i] = 0;
    mcount = 0; held = 0;
    exp_q.delete(); due_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // latency-timed patterns, output never refused
    lat_on = 1;
    for (int n = 0; n < 40; n++) step(1, 0, 1);
    drain();
    for (int n = 0; n < 40; n++) step(1, 50, 1);
    drain();
    for (int n = 0; n < 200; n++) step(1, ((n % 2) ? 40 : -40) + int'($urandom % 21) - 10, 1);
    drain();
    for (int n = 0; n < 300; n++) step(($urandom % 3) != 0, int'($urandom % 256) - 128, 1);
    drain();
    lat_on = 0;
    // random gaps and backpressure
    for (int n = 0; n < 800; n++)
      step(($urandom % 4) != 0, int'($urandom % 121) - 60, ($urandom % 3) != 0);
    drain();
    // saturation extremes with heavy refusal
    for (int n = 0; n < 200; n++)
      step(1, ($urandom % 2) ? 127 : -128, ($urandom % 2) != 0);
    drain();
    // R9: reset mid-fill restarts the 32-sample fill
    for (int n = 0; n < 20; n++) step(1, int'($urandom % 256) - 128, 1);
    do_reset();
    lat_on = 1;
    for (int n = 0; n < 31; n++) step(1, int'($urandom % 101) - 50, 1);
    drain();
    for (int n = 0; n < 9; n++) step(1, int'($urandom % 101) - 50, 1);
    drain();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule